// File: doc/BRIEF.md
# SIMT Core Instruction Sequencer

This block is the control state machine that walks one compute core through the instruction cycle for a block of threads that run in lock-step. Once a launch request arrives it steps through seven phases: idle, fetch, decode, operand request, wait, update and done. For each phase it raises one strobe, and the fetcher, decoder, register files, ALUs, program counter units and load/store units use these strobes to pace their work. There is no separate execute phase. ALU results and the next PC are computed in the wait phase, in the same cycles in which any outstanding memory response is awaited. Compared with a sequencer that has its own execute phase, this saves one cycle on every instruction.

The phase register has seven named states. Their transitions are:
- **IDLE→FETCH** on launch.
- **FETCH→FETCH** while the fetched instruction is not yet valid.
- **FETCH→DECODE** once it is valid.
- **DECODE→REQUEST** unconditionally.
- **REQUEST→WAIT** unconditionally.
- **WAIT→WAIT** while any thread's load/store unit is busy.
- **WAIT→UPDATE** otherwise.
- **UPDATE→DONE** when the decoded instruction is a return.
- **UPDATE→FETCH** otherwise.
- **DONE→DONE** until reset.

The busy state of each thread's load/store unit is reduced to one stall flag by a per-thread detector.

Top module: `core_sequencer`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) puts the sequencer in IDLE (phase code 0), with block_done_o and every strobe low, from any phase.
- R2: In IDLE the phase stays IDLE at every edge where launch_i is low. At an edge where launch_i is high, the next phase is FETCH (code 1).
- R3: FETCH holds at every edge where instr_valid_i is low. It moves to DECODE (code 2) at the first edge where instr_valid_i is high. Load/store status has no effect in FETCH.
- R4: DECODE lasts exactly one cycle and is followed by REQUEST (code 3). REQUEST lasts exactly one cycle and is followed by WAIT (code 4).
- R5: Thread t's load/store status is lsu_state_i[2t+1:2t], coded 0 idle, 1 requesting, 2 waiting, 3 done. WAIT holds at every edge where some thread reports 1 or 2. It moves to UPDATE (code 5) at the first edge where no thread does. Codes 0 and 3 never stall, so an instruction with no memory traffic spends exactly one cycle in WAIT.
- R6: UPDATE lasts one cycle. It is followed by DONE (code 6) if is_ret_i is high at that edge, and by FETCH otherwise.
- R7: DONE holds until reset, whatever launch_i, instr_valid_i and is_ret_i do. block_done_o is high exactly while the phase is DONE.
- R8: phase_o carries the phase code. Each strobe is high exactly in its own phase: fetch_go_o in FETCH, decode_go_o in DECODE, request_go_o in REQUEST, compute_go_o in WAIT and update_go_o in UPDATE. At most one strobe is high in any cycle, and none is high in IDLE or DONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| launch_i | input | 1 | Start request for the block |
| instr_valid_i | input | 1 | Fetcher reports the fetched instruction is valid |
| is_ret_i | input | 1 | Decoded instruction is a return |
| lsu_state_i | input | 2*THREADS | Per-thread load/store status, 2 bits per thread |
| phase_o | output | 3 | Current phase code |
| fetch_go_o | output | 1 | Fetch strobe |
| decode_go_o | output | 1 | Decode strobe |
| request_go_o | output | 1 | Operand request strobe |
| compute_go_o | output | 1 | ALU/PC compute strobe, high in WAIT |
| update_go_o | output | 1 | Register, flag and PC write strobe |
| block_done_o | output | 1 | Block finished |

## Verification
The hardest case to reach is a stall in WAIT that only one thread causes, with a busy code (requesting or waiting) that must still be seen while every other thread shows a non-stalling code. The sweep places a single busy thread at each lane position with each busy code, and holds it busy for zero, one or two cycles. It combines this with fetch latencies of zero to two cycles and programs of one to three instructions. It also presents busy status outside WAIT to show that it is ignored there. A reset issued in the middle of a block, and launch pulses sent in DONE, cover the remaining edges.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;

    localparam int PHASE_W = 3;
    localparam int LSU_W   = 2;

    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE    = 3'd0,
        PH_FETCH   = 3'd1,
        PH_DECODE  = 3'd2,
        PH_REQUEST = 3'd3,
        PH_WAIT    = 3'd4,
        PH_UPDATE  = 3'd5,
        PH_DONE    = 3'd6
    } phase_t;

    typedef enum logic [LSU_W-1:0] {
        LSU_IDLE = 2'd0,
        LSU_REQ  = 2'd1,
        LSU_WAIT = 2'd2,
        LSU_FIN  = 2'd3
    } lsu_t;

endpackage

// File: rtl/lsu_busy_detect.sv
`timescale 1ns/1ps
module lsu_busy_detect
    import seq_pkg::*;
#(
    parameter int THREADS = 4
) (
    input  logic [LSU_W*THREADS-1:0] lsu_state_i,
    output logic                     busy_o
);

    logic [THREADS-1:0] lane_busy;

    // One stall flag per thread: requesting or waiting holds the core.
    for (genvar t = 0; t < THREADS; t++) begin : g_lane
        lsu_t lane_st;
        assign lane_st = lsu_t'(lsu_state_i[LSU_W*t +: LSU_W]);
        always_comb begin
            unique case (lane_st)
                LSU_REQ,
                LSU_WAIT: lane_busy[t] = 1'b1;
                default:  lane_busy[t] = 1'b0;
            endcase
        end
    end

    assign busy_o = |lane_busy;

endmodule

// File: rtl/phase_fsm.sv
`timescale 1ns/1ps
module phase_fsm
    import seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   launch_i,
    input  logic   instr_valid_i,
    input  logic   lsu_busy_i,
    input  logic   is_ret_i,
    output phase_t phase_o
);

    phase_t cur_q;
    phase_t nxt;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) cur_q <= PH_IDLE;
        else     cur_q <= nxt;
    end

    // Next-state logic; ALU/PC work shares the WAIT phase with memory waits.
    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            PH_IDLE:    if (launch_i)      nxt = PH_FETCH;
            PH_FETCH:   if (instr_valid_i) nxt = PH_DECODE;
            PH_DECODE:                     nxt = PH_REQUEST;
            PH_REQUEST:                    nxt = PH_WAIT;
            PH_WAIT:    if (!lsu_busy_i)   nxt = PH_UPDATE;
            PH_UPDATE:  nxt = is_ret_i ? PH_DONE : PH_FETCH;
            PH_DONE:                       nxt = PH_DONE;
            default:                       nxt = PH_IDLE;
        endcase
    end

    assign phase_o = cur_q;

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (cur_q == PH_IDLE && !launch_i) |=> (cur_q == PH_IDLE));
    assert_idle_launch_R2: assert property (@(posedge clk) disable iff (rst)
        (cur_q == PH_IDLE && launch_i) |=> (cur_q == PH_FETCH));
    assert_fetch_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (cur_q == PH_FETCH && !instr_valid_i) |=> (cur_q == PH_FETCH));
    assert_decode_step_R4: assert property (@(posedge clk) disable iff (rst)
        (cur_q == PH_DECODE) |=> (cur_q == PH_REQUEST));
    assert_request_step_R4: assert property (@(posedge clk) disable iff (rst)
        (cur_q == PH_REQUEST) |=> (cur_q == PH_WAIT));
    assert_wait_stall_R5: assert property (@(posedge clk) disable iff (rst)
        (cur_q == PH_WAIT && lsu_busy_i) |=> (cur_q == PH_WAIT));
    assert_wait_release_R5: assert property (@(posedge clk) disable iff (rst)
        (cur_q == PH_WAIT && !lsu_busy_i) |=> (cur_q == PH_UPDATE));
    assert_update_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (cur_q == PH_UPDATE) |=> (cur_q == PH_DONE || cur_q == PH_FETCH));
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (cur_q == PH_DONE) |=> (cur_q == PH_DONE));

endmodule

// File: rtl/strobe_decode.sv
`timescale 1ns/1ps
module strobe_decode
    import seq_pkg::*;
(
    input  phase_t phase_i,
    output logic   fetch_go_o,
    output logic   decode_go_o,
    output logic   request_go_o,
    output logic   compute_go_o,
    output logic   update_go_o,
    output logic   done_o
);

    always_comb begin
        fetch_go_o   = 1'b0;
        decode_go_o  = 1'b0;
        request_go_o = 1'b0;
        compute_go_o = 1'b0;
        update_go_o  = 1'b0;
        done_o       = 1'b0;
        unique case (phase_i)
            PH_FETCH:   fetch_go_o   = 1'b1;
            PH_DECODE:  decode_go_o  = 1'b1;
            PH_REQUEST: request_go_o = 1'b1;
            PH_WAIT:    compute_go_o = 1'b1;
            PH_UPDATE:  update_go_o  = 1'b1;
            PH_DONE:    done_o       = 1'b1;
            default:    ;
        endcase
    end

    always_comb begin
        assert_strobe_onehot_R8: assert ($onehot0({fetch_go_o, decode_go_o,
            request_go_o, compute_go_o, update_go_o, done_o}));
    end

endmodule

// File: rtl/core_sequencer.sv
`timescale 1ns/1ps
module core_sequencer
    import seq_pkg::*;
#(
    parameter int THREADS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     launch_i,
    input  logic                     instr_valid_i,
    input  logic                     is_ret_i,
    input  logic [LSU_W*THREADS-1:0] lsu_state_i,
    output logic [PHASE_W-1:0]       phase_o,
    output logic                     fetch_go_o,
    output logic                     decode_go_o,
    output logic                     request_go_o,
    output logic                     compute_go_o,
    output logic                     update_go_o,
    output logic                     block_done_o
);

    logic   lsu_busy;
    phase_t cur_phase;

    lsu_busy_detect #(.THREADS(THREADS)) u_busy (
        .lsu_state_i (lsu_state_i),
        .busy_o      (lsu_busy)
    );

    phase_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .launch_i      (launch_i),
        .instr_valid_i (instr_valid_i),
        .lsu_busy_i    (lsu_busy),
        .is_ret_i      (is_ret_i),
        .phase_o       (cur_phase)
    );

    strobe_decode u_strobe (
        .phase_i      (cur_phase),
        .fetch_go_o   (fetch_go_o),
        .decode_go_o  (decode_go_o),
        .request_go_o (request_go_o),
        .compute_go_o (compute_go_o),
        .update_go_o  (update_go_o),
        .done_o       (block_done_o)
    );

    assign phase_o = cur_phase;

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (phase_o == 3'd0 && !block_done_o));
    assert_done_latched_R7: assert property (@(posedge clk) disable iff (rst)
        block_done_o |=> block_done_o);

endmodule

// File: tb/core_sequencer_test.sv
`timescale 1ns/1ps
module core_sequencer_test;

    localparam int NT = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          launch = 1'b0;
    logic          ivalid = 1'b0;
    logic          is_ret = 1'b0;
    logic [2*NT-1:0] lsu = '0;
    logic [2:0]    phase;
    logic          f_go, d_go, r_go, c_go, u_go, done;

    int errors = 0;
    int checks = 0;

    core_sequencer #(.THREADS(NT)) uut (
        .clk           (clk),
        .rst           (rst),
        .launch_i      (launch),
        .instr_valid_i (ivalid),
        .is_ret_i      (is_ret),
        .lsu_state_i   (lsu),
        .phase_o       (phase),
        .fetch_go_o    (f_go),
        .decode_go_o   (d_go),
        .request_go_o  (r_go),
        .compute_go_o  (c_go),
        .update_go_o   (u_go),
        .block_done_o  (done)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected strobe vector {fetch,decode,request,compute,update} per phase code.
    function automatic int strobe_of(input int ph);
        if (ph >= 1 && ph <= 5) return 1 << (5 - ph);
        return 0;
    endfunction

    task automatic expect_phase(input string req, input int ph);
        @(negedge clk);
        check({req, " phase"}, int'(phase), ph);
        check({req, " R8 strobes"}, int'({f_go, d_go, r_go, c_go, u_go}), strobe_of(ph));
        check({req, " R7 done"}, int'(done), (ph == 6) ? 1 : 0);
    endtask

    function automatic logic [2*NT-1:0] busy_pat(input int th, input int code);
        logic [2*NT-1:0] v;
        for (int t = 0; t < NT; t++) v[2*t +: 2] = (t == th) ? code[1:0] : 2'd3;
        return v;
    endfunction

    function automatic logic [2*NT-1:0] quiet_pat();
        logic [2*NT-1:0] v;
        for (int t = 0; t < NT; t++) v[2*t +: 2] = (t % 2 == 0) ? 2'd0 : 2'd3;
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; launch = 1'b0; ivalid = 1'b0; is_ret = 1'b0;
        expect_phase("R1 reset", 0);
        rst = 1'b0;
    endtask

    task automatic run_block(input int n, input int lat, input int th,
                             input int code, input int stall);
        do_reset();
        expect_phase("R2 idle hold", 0);
        expect_phase("R2 idle hold", 0);
        launch = 1'b1;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k <= lat; k++) begin
                expect_phase("R3 fetch", 1);
                launch = 1'b0;
                lsu = busy_pat(th, code);
                ivalid = (k == lat);
            end
            expect_phase("R4 decode", 2);
            ivalid = 1'b0;
            expect_phase("R4 request", 3);
            for (int k = 0; k <= stall; k++) begin
                expect_phase("R5 wait", 4);
                lsu = (k < stall) ? busy_pat(th, code) : quiet_pat();
            end
            expect_phase("R6 update", 5);
            is_ret = (i == n - 1);
            lsu = busy_pat(th, code);
        end
        for (int k = 0; k < 3; k++) begin
            expect_phase("R7 done hold", 6);
            launch = 1'b1; ivalid = 1'b1; is_ret = 1'b0;
        end
        launch = 1'b0; ivalid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int n = 1; n <= 3; n++)
            for (int lat = 0; lat <= 2; lat++)
                for (int th = 0; th < NT; th++)
                    for (int code = 1; code <= 2; code++)
                        for (int st = 0; st <= 2; st++)
                            run_block(n, lat, th, code, st);

        // R1: reset in the middle of a block returns to IDLE.
        do_reset();
        launch = 1'b1;
        expect_phase("R2 launch", 1);
        launch = 1'b0; ivalid = 1'b1;
        expect_phase("R3 fetch valid", 2);
        ivalid = 1'b0; rst = 1'b1;
        expect_phase("R1 mid-block reset", 0);
        rst = 1'b0;
        expect_phase("R2 idle after reset", 0);

        // R1: reset out of DONE.
        run_block(1, 0, 0, 1, 0);
        rst = 1'b1;
        expect_phase("R1 reset from done", 0);
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule